// File: doc/BRIEF.md
# Partitioned SIMD Adder with Per-Lane Carry

This block is a 16-bit combinational adder whose datapath can be split into independent lanes. The adder is built from four 4-bit chunks. A partition mask decides, at each chunk seam, whether the carry runs on into the next chunk or the seam closes and the next chunk starts a new lane. The same hardware therefore works as one 16-bit adder, two 8-bit adders, four 4-bit adders, or a mix of lane sizes such as 4+4+8.

Each lane adds its slice of the two operands plus its own carry-in. A lane reads its carry-in from the bit of its lowest chunk and reports its carry-out in the bit of its highest chunk. No overflow leaks across a closed seam. There is no register in the block. A surrounding pipeline registers the operands and the results as it needs.

Top module: `simd_part_adder`

## Requirements
- R1: Chunk k covers result bits 4k+3 down to 4k. A set bit k of `part_mask` (k = 0, 1, 2) closes the seam between chunk k and chunk k+1, so a new lane starts at bit 4(k+1). A mask of 0 gives one 16-bit lane, 3'b010 gives two 8-bit lanes, and 3'b111 gives four 4-bit lanes.
- R2: For every lane, the matching slice of `sum` equals (a_lane + b_lane + cin_lane) modulo 2^(lane width).
- R3: A carry never crosses a closed seam. A lane's result does not depend on the operands or carry-ins of any other lane.
- R4: A lane takes `carry_in` bit j, where j is the index of its lowest chunk, and adds it at the lane's least significant bit. The `carry_in` bits of the other chunks in the lane have no effect.
- R5: `carry_out` bit j, where j is the index of a lane's highest chunk, equals bit (lane width) of a_lane + b_lane + cin_lane. Every other `carry_out` bit reads 0.
- R6: Bit 3 of `part_mask` is not a real partition point and has no effect on `sum` or `carry_out`.
- R7: The block is purely combinational. `sum` and `carry_out` follow a change of any input within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 4 | Carry-in, one bit per 4-bit chunk; only a lane's lowest chunk bit is used |
| part_mask | input | 4 | Seam closures; bit k closes the seam at bit 4(k+1); bit 3 ignored |
| sum | output | 16 | Lane-wise sums |
| carry_out | output | 4 | Lane carry-outs, in the bit of each lane's highest chunk |

## Verification
The assertions check these on every input change: the arithmetic of each chunk, the mapping from mask to seams, the choice between an external carry and a chained carry at each seam, and that interior carry-out bits stay at zero. They cannot show that whole lanes give the right results, that carry-ins of inner chunks and mask bit 3 truly have no effect on the outputs, or that results settle within the cycle. The bench's scenarios show these by comparing every cycle against a lane-by-lane integer model. The scenarios cover every mask value, carries that ripple the full length of a lane, and carry-in patterns that set only inner chunk bits.

// File: rtl/spa_pkg.sv
package spa_pkg;
  localparam int CHUNK_W  = 4;
  localparam int N_CHUNKS = 4;
  localparam int DATA_W   = CHUNK_W * N_CHUNKS;

  // Width of a lane that runs from chunk lo up to chunk hi, inclusive.
  function automatic int lane_bits(input int lo, input int hi);
    return (hi - lo + 1) * CHUNK_W;
  endfunction
endpackage

// File: rtl/spa_seam_decode.sv
// Turns the seam-closure mask into two flags per chunk:
// first_of_lane (chunk starts a lane) and last_of_lane (chunk ends a lane).
module spa_seam_decode #(
  parameter int N_CHUNKS = spa_pkg::N_CHUNKS
) (
  input  logic [N_CHUNKS-2:0] seam_closed,
  output logic [N_CHUNKS-1:0] first_of_lane,
  output logic [N_CHUNKS-1:0] last_of_lane
);
  for (genvar k = 0; k < N_CHUNKS; k++) begin : g_seam
    if (k == 0) begin : g_lo_first
      assign first_of_lane[k] = 1'b1;
    end else begin : g_lo_rest
      assign first_of_lane[k] = seam_closed[k-1];
    end
    if (k == N_CHUNKS - 1) begin : g_hi_last
      assign last_of_lane[k] = 1'b1;
    end else begin : g_hi_rest
      assign last_of_lane[k] = seam_closed[k];
    end
  end
endmodule

// File: rtl/spa_chunk_add.sv
// One chunk of the adder: a W-bit add with carry in and carry out.
module spa_chunk_add #(
  parameter int W = spa_pkg::CHUNK_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  assign {co, s} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder #(
  parameter int CHUNK_W  = spa_pkg::CHUNK_W,
  parameter int N_CHUNKS = spa_pkg::N_CHUNKS,
  localparam int DATA_W  = CHUNK_W * N_CHUNKS
) (
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [N_CHUNKS-1:0] carry_in,
  input  logic [N_CHUNKS-1:0] part_mask,
  output logic [DATA_W-1:0]   sum,
  output logic [N_CHUNKS-1:0] carry_out
);
  // Named wires brought out for the checker.
  logic [N_CHUNKS-1:0] first_of_lane;
  logic [N_CHUNKS-1:0] last_of_lane;
  logic [N_CHUNKS-1:0] chunk_ci;
  logic [N_CHUNKS-1:0] chunk_co;

  // The top mask bit has no seam behind it.
  logic mask_top_unused;
  assign mask_top_unused = part_mask[N_CHUNKS-1];

  spa_seam_decode #(.N_CHUNKS(N_CHUNKS)) u_seam (
    .seam_closed  (part_mask[N_CHUNKS-2:0]),
    .first_of_lane(first_of_lane),
    .last_of_lane (last_of_lane)
  );

  for (genvar k = 0; k < N_CHUNKS; k++) begin : g_chunk
    logic c_in;
    logic c_out;
    if (k == 0) begin : g_ci0
      assign c_in = carry_in[0];
    end else begin : g_cik
      // At a closed seam, inject the lane's own carry-in; otherwise chain.
      assign c_in = first_of_lane[k] ? carry_in[k] : g_chunk[k-1].c_out;
    end

    spa_chunk_add #(.W(CHUNK_W)) u_add (
      .x (op_a[k*CHUNK_W +: CHUNK_W]),
      .y (op_b[k*CHUNK_W +: CHUNK_W]),
      .ci(c_in),
      .s (sum[k*CHUNK_W +: CHUNK_W]),
      .co(c_out)
    );

    assign chunk_ci[k]  = c_in;
    assign chunk_co[k]  = c_out;
    assign carry_out[k] = last_of_lane[k] & c_out;
  end
endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
  parameter int CHUNK_W  = spa_pkg::CHUNK_W,
  parameter int N_CHUNKS = spa_pkg::N_CHUNKS,
  localparam int DATA_W  = CHUNK_W * N_CHUNKS
) (
  input logic [DATA_W-1:0]   op_a,
  input logic [DATA_W-1:0]   op_b,
  input logic [N_CHUNKS-1:0] carry_in,
  input logic [N_CHUNKS-1:0] part_mask,
  input logic [DATA_W-1:0]   sum,
  input logic [N_CHUNKS-1:0] carry_out,
  input logic [N_CHUNKS-1:0] first_of_lane,
  input logic [N_CHUNKS-1:0] last_of_lane,
  input logic [N_CHUNKS-1:0] chunk_ci,
  input logic [N_CHUNKS-1:0] chunk_co
);
  always_comb begin
    for (int k = 0; k < N_CHUNKS; k++) begin
      // R2
      chunk_arith_chk: assert ({chunk_co[k], sum[k*CHUNK_W +: CHUNK_W]} ==
          ({1'b0, op_a[k*CHUNK_W +: CHUNK_W]} + {1'b0, op_b[k*CHUNK_W +: CHUNK_W]} +
           {{CHUNK_W{1'b0}}, chunk_ci[k]}))
        else $error("chunk %0d arithmetic mismatch", k);
      // R4
      if (first_of_lane[k]) begin
        lane_cin_chk: assert (chunk_ci[k] == carry_in[k])
          else $error("chunk %0d did not take its own carry-in", k);
      end
    end
    for (int k = 1; k < N_CHUNKS; k++) begin
      // R3
      if (!first_of_lane[k]) begin
        open_seam_chain_chk: assert (chunk_ci[k] == chunk_co[k-1])
          else $error("open seam %0d did not chain the carry", k);
      end
    end
    for (int k = 0; k < N_CHUNKS - 1; k++) begin
      // R1
      seam_map_chk: assert (last_of_lane[k] == part_mask[k] &&
                            first_of_lane[k+1] == part_mask[k])
        else $error("seam %0d decoded wrongly", k);
    end
    // R5
    interior_cout_chk: assert ((carry_out & ~last_of_lane) == '0)
      else $error("interior carry-out bit set");
    // R6
    outer_edges_chk: assert (first_of_lane[0] && last_of_lane[N_CHUNKS-1])
      else $error("outer lane edges not fixed");
  end
endmodule

bind simd_part_adder spa_checker #(.CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS)) u_chk (
  .op_a         (op_a),
  .op_b         (op_b),
  .carry_in     (carry_in),
  .part_mask    (part_mask),
  .sum          (sum),
  .carry_out    (carry_out),
  .first_of_lane(first_of_lane),
  .last_of_lane (last_of_lane),
  .chunk_ci     (chunk_ci),
  .chunk_co     (chunk_co)
);

// File: tb/sim_simd_part_adder.sv
`timescale 1ns/1ps
module sim_simd_part_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [3:0]  carry_in = '0, part_mask = '0;
  logic [15:0] sum;
  logic [3:0]  carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  simd_part_adder u0 (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .part_mask(part_mask),
    .sum(sum), .carry_out(carry_out)
  );

  // Behavioural model: walk lanes as integers, closing one at each set mask bit.
  task automatic model(input int a, input int b, input int ci, input int m,
                       output int exp_s, output int exp_c);
    int lo, w, s;
    exp_s = 0; exp_c = 0; lo = 0;
    for (int k = 0; k < 4; k++) begin
      if (k == 3 || ((m >> k) & 1) == 1) begin
        w = (k - lo + 1) * 4;
        s = ((a >> (lo*4)) & ((1 << w) - 1)) + ((b >> (lo*4)) & ((1 << w) - 1))
            + ((ci >> lo) & 1);
        exp_s = exp_s | ((s & ((1 << w) - 1)) << (lo*4));
        exp_c = exp_c | (((s >> w) & 1) << k);
        lo = k + 1;
      end
    end
  endtask

  // Drive just after a rising edge, compare at the following falling edge (R7).
  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] ci, input logic [3:0] m, input string tag);
    int es, ec;
    @(posedge clk); #0.5;
    op_a = a; op_b = b; carry_in = ci; part_mask = m;
    model(int'(a), int'(b), int'(ci), int'(m), es, ec);
    @(negedge clk);
    checks++;
    if (sum !== es[15:0]) begin
      errors++;
      $display("FAIL %s sum: a=%h b=%h ci=%b m=%b actual=%h expected=%h",
               tag, a, b, ci, m, sum, es[15:0]);
    end
    checks++;
    if (carry_out !== ec[3:0]) begin
      errors++;
      $display("FAIL %s carry_out: a=%h b=%h ci=%b m=%b actual=%b expected=%b",
               tag, a, b, ci, m, carry_out, ec[3:0]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R7 reset state: all-zero inputs give zero outputs.
    @(negedge clk);
    checks++;
    if (sum !== 16'h0 || carry_out !== 4'h0) begin
      errors++;
      $display("FAIL R7 reset: actual=%h/%b expected=0000/0000", sum, carry_out);
    end
    // R1 R2: the three standard lane layouts.
    for (int mi = 0; mi < 3; mi++) begin
      logic [3:0] m;
      m = (mi == 0) ? 4'b0000 : (mi == 1) ? 4'b0010 : 4'b0111;
      apply(16'h1234, 16'h4321, 4'h0, m, "R1");
      apply(16'h8888, 16'h8888, 4'h0, m, "R2");
      apply(16'h00FF, 16'h0001, 4'h0, m, "R2");
      apply(16'hFFFF, 16'hFFFF, 4'hF, m, "R2");
    end
    // R3: full ripple stops at each closed seam.
    apply(16'hFFFF, 16'h0001, 4'h0, 4'b0000, "R3");
    apply(16'hFFFF, 16'h0001, 4'h0, 4'b0010, "R3");
    apply(16'hFFFF, 16'h0001, 4'h0, 4'b0111, "R3");
    apply(16'hFFFF, 16'h0001, 4'h0, 4'b0001, "R3");
    apply(16'h0FFF, 16'h0001, 4'h0, 4'b0100, "R3");
    // R4: inner-chunk carry-ins ignored, lowest-chunk carry-in used.
    apply(16'h0000, 16'h0000, 4'b1110, 4'b0000, "R4");
    apply(16'h00FF, 16'h0000, 4'b0001, 4'b0000, "R4");
    apply(16'h0000, 16'h0000, 4'b1010, 4'b0010, "R4");
    apply(16'h0000, 16'h0000, 4'b0100, 4'b0010, "R4");
    apply(16'hFFFF, 16'h0000, 4'b1111, 4'b0111, "R4");
    // R5: carry-out lands only in the top chunk of each lane.
    apply(16'hF000, 16'h1000, 4'h0, 4'b0000, "R5");
    apply(16'h0F00, 16'h0100, 4'h0, 4'b0010, "R5");
    apply(16'h80F0, 16'h8010, 4'h0, 4'b0101, "R5");
    // R6: top mask bit has no effect.
    apply(16'hFFFF, 16'h0001, 4'h1, 4'b1000, "R6");
    apply(16'hABCD, 16'h9876, 4'hF, 4'b1010, "R6");
    apply(16'hFFFF, 16'hFFFF, 4'h5, 4'b1111, "R6");
    // R2 R3 R4 R5: random sweep over every mask, new vector each cycle.
    for (int i = 0; i < 400; i++) begin
      apply(16'($urandom), 16'($urandom), 4'($urandom), 4'(i % 16), "R2");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule